// File: doc/BRIEF.md
# I2C Acknowledge Polling Sequencer

This block sits on the master side of an I2C bus. It drives a byte-level I2C master engine. After a serial EEPROM has received a write command and the bus has been released with a stop, the device runs an internally timed programming cycle. While that cycle runs, the device does not acknowledge its own address. Rather than waiting out a worst-case delay, the sequencer probes the device repeatedly. Each probe is a start condition followed by the device address with the direction bit cleared. A missing acknowledge means the device is still busy, so the sequencer ends that probe with a stop and tries again.

One go pulse captures the 7-bit device address and the retry limit. When a probe is acknowledged, the sequencer pulses done for one cycle and leaves the bus held with no stop. A follow-on read or write command can then continue on the same transfer. If the limit of unanswered probes is reached, the sequencer sends a stop and pulses err instead. Polling may start on the cycle after the preceding stop, with no wait.

The engine interface uses a request/response pair. A request (operation code plus byte) is held until the engine accepts it. The engine later reports completion with a one-cycle response that carries the acknowledge status of a byte write.

Top module: `ackpoll_seq`

## Requirements
- R1: A go pulse while idle starts a probe, and the first request issued is a start condition (cmd_op code 0).
- R2: After the start completes, the next request is a byte write (cmd_op code 2) whose byte is the device address captured at go in bits 7:1, with bit 0 (the direction bit) equal to 0. Later changes of dev_addr do not affect a running sequence.
- R3: When the byte write completes with rsp_nack=1 and the limit has not been reached, the sequencer issues a stop (cmd_op code 1) and then a new start, so the probe repeats.
- R4: When the byte write completes with rsp_nack=0, done is high for exactly one cycle, no stop is issued, and no further request follows until the next go.
- R5: Unacknowledged probes are counted. When their number reaches max_tries (captured at go; a value of 0 acts as 1), the sequencer issues a stop, then pulses err for exactly one cycle and makes no further probe.
- R6: go is ignored while a sequence is in progress: it neither restarts the probe count nor changes the captured address.
- R7: cmd_valid, cmd_op and cmd_byte stay stable until cmd_ready accepts the request. No new request is raised between an acceptance and the matching rsp_valid.
- R8: While rst is high and after it falls, cmd_valid, done and err are low until a go arrives.
- R9: done and err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a polling sequence (sampled only when idle) |
| dev_addr | input | 7 | Device address, captured at go |
| max_tries | input | TRY_W | Limit of unacknowledged probes, captured at go |
| cmd_valid | output | 1 | Request to the byte engine is pending |
| cmd_op | output | 2 | Request code: 0 start, 1 stop, 2 byte write |
| cmd_byte | output | 8 | Byte for a write request |
| cmd_ready | input | 1 | Engine accepts the pending request |
| rsp_valid | input | 1 | Engine has finished the accepted request |
| rsp_nack | input | 1 | With rsp_valid on a byte write: 1 when no acknowledge was received |
| done | output | 1 | One-cycle pulse: device acknowledged |
| err | output | 1 | One-cycle pulse: retry limit reached |

## Verification
A controller stuck in or skipping a state shows up on the request stream within one engine round trip. Examples are a stop where a start belongs, a write without a preceding start, or a sequence that never issues its first start. A wrong probe count shows up as one request triple too many or too few before err. It can also show as done after a refused probe, visible when the sequence ends. A latched address or limit that is re-captured by a stray go alters the probe byte or the number of attempts within the same sequence.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    localparam int DEV_ADDR_W = 7;
    localparam int BYTE_W     = 8;

    // Request codes seen by the byte engine
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_STOP
    } poll_st_e;

    typedef struct packed {
        bus_op_e             op;
        logic [BYTE_W-1:0]   data;
    } bus_req_t;

    // Address byte for a write-direction probe
    function automatic logic [BYTE_W-1:0] probe_byte(input logic [DEV_ADDR_W-1:0] a);
        return {a, 1'b0};
    endfunction

endpackage

// File: rtl/ackpoll_try_cnt.sv
module ackpoll_try_cnt #(
    parameter int TRY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TRY_W-1:0] limit_in,
    input  logic             bump,
    output logic             last
);
    localparam int CMP_W = TRY_W + 1;

    logic [TRY_W-1:0] limit_q;
    logic [TRY_W-1:0] used_q;
    logic [CMP_W-1:0] used_next;

    assign used_next = {1'b0, used_q} + CMP_W'(1);
    // a limit of zero compares like one: the first refusal is the last
    assign last = (used_next >= {1'b0, limit_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            used_q  <= '0;
        end else if (load) begin
            limit_q <= limit_in;
            used_q  <= '0;
        end else if (bump && !(&used_q)) begin
            used_q  <= used_q + TRY_W'(1);
        end
    end

endmodule

// File: rtl/ackpoll_cmd_port.sv
module ackpoll_cmd_port
    import ackpoll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  bus_req_t          req,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    input  logic              cmd_ready,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    output logic              fin,
    output logic              fin_nack
);
    logic     valid_q;
    logic     wait_q;
    bus_req_t req_q;

    assign cmd_valid = valid_q;
    assign cmd_op    = req_q.op;
    assign cmd_byte  = req_q.data;
    assign fin       = wait_q && rsp_valid;
    assign fin_nack  = rsp_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            wait_q  <= 1'b0;
            req_q   <= '{op: OP_STOP, data: '0};
        end else begin
            if (issue) begin
                valid_q <= 1'b1;
                req_q   <= req;
            end else if (valid_q && cmd_ready) begin
                valid_q <= 1'b0;
                wait_q  <= 1'b1;
            end
            if (fin) begin
                wait_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ackpoll_ctrl.sv
module ackpoll_ctrl
    import ackpoll_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [DEV_ADDR_W-1:0] dev_addr,
    input  logic                  fin,
    input  logic                  fin_nack,
    input  logic                  try_last,
    output logic                  try_load,
    output logic                  try_bump,
    output logic                  issue,
    output bus_req_t              req,
    output logic                  done,
    output logic                  err
);
    poll_st_e              st_q, st_n;
    logic                  launch_q, launch_n;
    logic                  done_q, done_n;
    logic                  err_q, err_n;
    logic                  quit_q, quit_n;
    logic [DEV_ADDR_W-1:0] addr_q;

    assign issue = launch_q;
    assign done  = done_q;
    assign err   = err_q;

    always_comb begin
        unique case (st_q)
            ST_START: req = '{op: OP_START, data: '0};
            ST_ADDR:  req = '{op: OP_WRITE, data: probe_byte(addr_q)};
            default:  req = '{op: OP_STOP,  data: '0};
        endcase
    end

    always_comb begin
        st_n     = st_q;
        launch_n = 1'b0;
        done_n   = 1'b0;
        err_n    = 1'b0;
        quit_n   = quit_q;
        try_load = 1'b0;
        try_bump = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_n     = ST_START;
                    launch_n = 1'b1;
                    try_load = 1'b1;
                    quit_n   = 1'b0;
                end
            end
            ST_START: begin
                if (fin) begin
                    st_n     = ST_ADDR;
                    launch_n = 1'b1;
                end
            end
            ST_ADDR: begin
                if (fin) begin
                    if (!fin_nack) begin
                        st_n   = ST_IDLE;
                        done_n = 1'b1;
                    end else begin
                        st_n     = ST_STOP;
                        launch_n = 1'b1;
                        try_bump = 1'b1;
                        quit_n   = try_last;
                    end
                end
            end
            ST_STOP: begin
                if (fin) begin
                    if (quit_q) begin
                        st_n  = ST_IDLE;
                        err_n = 1'b1;
                    end else begin
                        st_n     = ST_START;
                        launch_n = 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            launch_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            quit_q   <= 1'b0;
            addr_q   <= '0;
        end else begin
            st_q     <= st_n;
            launch_q <= launch_n;
            done_q   <= done_n;
            err_q    <= err_n;
            quit_q   <= quit_n;
            if (st_q == ST_IDLE && go) begin
                addr_q <= dev_addr;
            end
        end
    end

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int TRY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [DEV_ADDR_W-1:0] dev_addr,
    input  logic [TRY_W-1:0]      max_tries,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_op,
    output logic [BYTE_W-1:0]     cmd_byte,
    input  logic                  cmd_ready,
    input  logic                  rsp_valid,
    input  logic                  rsp_nack,
    output logic                  done,
    output logic                  err
);
    logic     issue;
    bus_req_t req;
    logic     fin, fin_nack;
    logic     try_load, try_bump, try_last;

    ackpoll_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .dev_addr (dev_addr),
        .fin      (fin),
        .fin_nack (fin_nack),
        .try_last (try_last),
        .try_load (try_load),
        .try_bump (try_bump),
        .issue    (issue),
        .req      (req),
        .done     (done),
        .err      (err)
    );

    ackpoll_try_cnt #(.TRY_W(TRY_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (try_load),
        .limit_in (max_tries),
        .bump     (try_bump),
        .last     (try_last)
    );

    ackpoll_cmd_port u_port (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .req       (req),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_nack  (rsp_nack),
        .fin       (fin),
        .fin_nack  (fin_nack)
    );

endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk
    import ackpoll_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic [7:0]  cmd_byte,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_nack,
    input logic        done,
    input logic        err
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)                          pend_q <= 1'b0;
        else if (cmd_valid && cmd_ready)  pend_q <= 1'b1;
        else if (rsp_valid)               pend_q <= 1'b0;
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

    assert_one_pending_R7: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !cmd_valid);

    assert_write_dir_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_WRITE |-> !cmd_byte[0]);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rsp_valid && !rsp_nack));

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

endmodule

bind ackpoll_seq ackpoll_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack),
    .done      (done),
    .err       (err)
);

// File: tb/tb_ackpoll_seq.sv
module tb_ackpoll_seq;
    localparam int TRY_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             go = 1'b0;
    logic [6:0]       dev_addr = '0;
    logic [TRY_W-1:0] max_tries = '0;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [7:0]       cmd_byte;
    logic             cmd_ready = 1'b0;
    logic             rsp_valid = 1'b0;
    logic             rsp_nack = 1'b0;
    logic             done, err;

    ackpoll_seq #(.TRY_W(TRY_W)) dut (.*);

    always #2 clk = ~clk;

    int n_checks = 0, n_errs = 0;
    int busy_left = 0;
    logic [7:0] exp_byte = '0;
    int n_start, n_stop, n_write, n_done, n_err, bad_byte, bad_order, dbl_pulse, both_hi, last_op;
    int cyc = 0;
    logic prev_done = 0, prev_err = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_start = 0; n_stop = 0; n_write = 0; n_done = 0; n_err = 0;
        bad_byte = 0; bad_order = 0; dbl_pulse = 0; both_hi = 0; last_op = -1;
    endtask

    // byte-engine model: records every accepted request
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (cmd_valid && !rst) begin
                automatic logic [1:0] op = cmd_op;
                automatic logic [7:0] b  = cmd_byte;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                case (op)
                    2'd0: begin n_start++; if (!(last_op == -1 || last_op == 1)) bad_order++; end
                    2'd2: begin n_write++; if (last_op != 0) bad_order++; if (b != exp_byte) bad_byte++; end
                    2'd1: begin n_stop++;  if (last_op != 2) bad_order++; end
                    default: bad_order++;
                endcase
                last_op = int'(op);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                rsp_nack = (op == 2'd2) && (busy_left > 0);
                if (op == 2'd2 && busy_left > 0) busy_left--;
                rsp_valid = 1'b1;
            end
        end
    end

    // pulse monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (done) n_done++;
            if (err) n_err++;
            if ((done && prev_done) || (err && prev_err)) dbl_pulse++;
            if (done && err) both_hi++;
        end
        prev_done = done;
        prev_err  = err;
        if (cyc > 150000) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    task automatic run_case(input logic [6:0] a, input int lim, input int busy, input bit stray_go);
        int eff, att;
        bit ok_end;
        eff = (lim == 0) ? 1 : lim;
        @(negedge clk);
        clear_counts();
        busy_left = busy;
        exp_byte  = {a, 1'b0};
        dev_addr  = a;
        max_tries = TRY_W'(lim);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        dev_addr  = ~a;             // R2: later change must not matter
        max_tries = TRY_W'(lim + 3);
        if (stray_go) begin          // R6
            repeat (6) @(negedge clk);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        for (int i = 0; i < 8000 && n_done == 0 && n_err == 0; i++) @(negedge clk);
        repeat (30) @(negedge clk);
        ok_end = (busy < eff);
        att = ok_end ? busy + 1 : eff;
        check(n_start == att, "R1/R3 start count", n_start, att);
        check(n_write == att, "R2 write count", n_write, att);
        check(n_stop == (ok_end ? busy : eff), ok_end ? "R3/R4 stop count" : "R5 stop count",
              n_stop, ok_end ? busy : eff);
        check(bad_byte == 0, "R2/R6 probe byte", bad_byte, 0);
        check(bad_order == 0, "R1/R3 request order", bad_order, 0);
        check(n_done == (ok_end ? 1 : 0), "R4 done pulses", n_done, ok_end ? 1 : 0);
        check(n_err == (ok_end ? 0 : 1), "R5 err pulses", n_err, ok_end ? 0 : 1);
        check(dbl_pulse == 0 && both_hi == 0, "R9 single exclusive pulses", dbl_pulse + both_hi, 0);
        check(!cmd_valid, "R4/R5 idle after end", int'(cmd_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        clear_counts();
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done && !err, "R8 outputs in reset", int'({cmd_valid, done, err}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!cmd_valid && !done && !err, "R8 outputs after reset", int'({cmd_valid, done, err}), 0);
        // directed corners
        run_case(7'h50, 1, 0, 0);   // immediate ack
        run_case(7'h51, 0, 0, 0);   // zero limit, ack
        run_case(7'h52, 0, 1, 0);   // zero limit acts as one
        run_case(7'h53, 3, 3, 0);   // exactly at limit
        run_case(7'h54, 3, 2, 0);   // last allowed probe acknowledged
        run_case(7'h55, 20, 5, 1);  // stray go while busy
        run_case(7'h56, 2, 6, 1);   // stray go, failing
        // random mix
        for (int k = 0; k < 16; k++) begin
            run_case(7'($urandom), int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                     1'($urandom_range(0, 1)));
        end
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule